// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single line. A character written by the host goes into a holding buffer. When the output shifter has no frame in progress, the character moves into the shifter and the buffer is free for the next write. The two stages have separate status flags, so the host can keep the line busy without any gap between frames.

The frame format comes from run-time mode inputs: 5 to 8 data bits, optional odd or even parity, and 1, 1.5 or 2 stop bits. A transmit tick enable paces the bits, and each bit lasts 1, 16 or 64 ticks. The format is captured when a frame starts. A transmit-enable input stops new frames from starting, and a break input forces the line low.

Top module: `ser_tx_top`

## Requirements
- R1: After reset, with `tx_en_i` high, `txd_o` is high, `tx_rdy_o` is high and `tx_empty_o` is high.
- R2: A frame is a low start bit, then the data bits LSB first, then high stop bits. The count of data bits is 5, 6, 7 or 8 for `len_sel_i` codes 00, 01, 10 and 11, and data bits above that count are not sent. The line is high between frames.
- R3: With `par_en_i` high, one parity bit follows the data. With `par_even_i` at 1, the data bits plus the parity bit hold an even number of ones; with 0, an odd number.
- R4: Every start, data and parity bit lasts 1, 16 or 64 `tick_i` pulses for `rate_sel_i` codes 01, 10 and 11. Code 00 acts as 01.
- R5: The stop interval lasts 1, 1.5 or 2 bit times for `stop_sel_i` codes 01, 10 and 11, which gives 24 ticks at x16 and 96 ticks at x64 for code 10. At x1, code 10 gives 2 ticks. Code 00 acts as 01.
- R6: A write with the buffer empty sets `tx_rdy_o` low on the next cycle. The character moves to the shifter on the first cycle in which the shifter is free, and `tx_rdy_o` then goes high again. A buffered character starts on the tick that ends the previous stop interval, so there is no idle gap.
- R7: A write while the holding buffer is full is ignored, and no frame is sent for it.
- R8: `tx_empty_o` is low from the cycle after a frame starts until its stop interval ends, and high otherwise.
- R9: While `tx_en_i` is low, `tx_rdy_o` is low and no frame starts, though the buffer still takes a write. A frame already running completes. A buffered character starts once `tx_en_i` returns high.
- R10: While `brk_i` is high, `txd_o` is low.
- R11: Changes to the mode inputs during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Transmit tick enable, one pulse per tick |
| len_sel_i | input | 2 | Data length code (5 to 8 bits) |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| stop_sel_i | input | 2 | Stop length code |
| rate_sel_i | input | 2 | Ticks-per-bit code |
| tx_en_i | input | 1 | Transmit enable |
| brk_i | input | 1 | Force line low |
| wr_i | input | 1 | Write strobe for the holding buffer |
| wdata_i | input | 8 | Character to send |
| txd_o | output | 1 | Serial line |
| tx_rdy_o | output | 1 | Holding buffer empty and transmit enabled |
| tx_empty_o | output | 1 | No frame in progress |

## Verification
The bench measures the line tick by tick against expected frames, so errors in the tick count show up directly. These include a stop interval at 1.5 bits that is rounded the wrong way (16 or 32 ticks instead of 24), or a x1 setting that yields 1 tick instead of 2. Back-to-back writes check that the next start bit comes right after the stop interval. A design that needed an idle tick between frames, or that overwrote a full buffer, would produce shifted or extra frames. The bench also drops transmit enable in the middle of a frame and changes the mode inputs during a frame. A design that cut the frame short, started a buffered character while disabled, or read the live mode inputs would send a frame that differs from the expected one.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  localparam int TICK_W = 8;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_DATA  = 2'd1,
    PH_PAR   = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  function automatic logic [TICK_W-1:0] bit_ticks(input logic [1:0] rate);
    case (rate)
      2'b10:   bit_ticks = TICK_W'(16);
      2'b11:   bit_ticks = TICK_W'(64);
      default: bit_ticks = TICK_W'(1);
    endcase
  endfunction

  // 1.5 stop at x1 rounds up to two ticks
  function automatic logic [TICK_W-1:0] stop_ticks(input logic [1:0] rate,
                                                   input logic [1:0] stop);
    logic [TICK_W-1:0] b;
    b = bit_ticks(rate);
    case (stop)
      2'b10:   stop_ticks = (rate[1]) ? b + (b >> 1) : TICK_W'(2);
      2'b11:   stop_ticks = b << 1;
      default: stop_ticks = b;
    endcase
  endfunction

endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (wr_i && !full_o) begin
      full_o <= 1'b1;
      data_o <= wdata_i;
    end
  end

  p_full_write_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_i) |=> (data_o == $past(data_o)));

endmodule

// File: rtl/ser_tx_timer.sv
module ser_tx_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [CW-1:0] len_i,
  output logic          seg_end_o
);

  logic [CW-1:0] cnt_q;

  assign seg_end_o = run_i && tick_i && (cnt_q == len_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i || seg_end_o)   cnt_q <= '0;
    else if (run_i && tick_i)          cnt_q <= cnt_q + CW'(1);
  end

  p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_i));

endmodule

// File: rtl/ser_tx_frame.sv
module ser_tx_frame
  import ser_tx_pkg::*;
#(
  parameter int CW = TICK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [7:0]    ld_data_i,
  input  logic [1:0]    ld_len_i,
  input  logic          ld_par_en_i,
  input  logic          ld_par_even_i,
  input  logic [1:0]    ld_rate_i,
  input  logic [1:0]    ld_stop_i,
  input  logic          seg_end_i,
  output logic          busy_o,
  output logic          stop_end_o,
  output logic          line_o,
  output logic [CW-1:0] seg_len_o
);

  phase_e        phase_q;
  logic [2:0]    idx_q;
  logic [7:0]    shreg_q;
  logic          par_q;
  logic [1:0]    len_q;
  logic          par_en_q;
  logic [CW-1:0] bit_len_q;
  logic [CW-1:0] stop_len_q;

  logic [7:0] ld_masked;
  logic [2:0] last_idx;

  assign ld_masked  = ld_data_i & (8'hFF >> (2'd3 - ld_len_i));
  assign last_idx   = {1'b0, len_q} + 3'd4;
  assign seg_len_o  = (phase_q == PH_STOP) ? stop_len_q : bit_len_q;
  assign stop_end_o = busy_o && (phase_q == PH_STOP) && seg_end_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      phase_q    <= PH_START;
      idx_q      <= '0;
      shreg_q    <= '0;
      par_q      <= 1'b0;
      len_q      <= '0;
      par_en_q   <= 1'b0;
      bit_len_q  <= CW'(1);
      stop_len_q <= CW'(1);
    end else if (load_i) begin
      busy_o     <= 1'b1;
      phase_q    <= PH_START;
      idx_q      <= '0;
      shreg_q    <= ld_masked;
      par_q      <= ld_par_even_i ? (^ld_masked) : ~(^ld_masked);
      len_q      <= ld_len_i;
      par_en_q   <= ld_par_en_i;
      bit_len_q  <= bit_ticks(ld_rate_i);
      stop_len_q <= stop_ticks(ld_rate_i, ld_stop_i);
    end else if (busy_o && seg_end_i) begin
      case (phase_q)
        PH_START: phase_q <= PH_DATA;
        PH_DATA: begin
          shreg_q <= shreg_q >> 1;
          idx_q   <= idx_q + 3'd1;
          if (idx_q == last_idx) phase_q <= par_en_q ? PH_PAR : PH_STOP;
        end
        PH_PAR:  phase_q <= PH_STOP;
        default: busy_o <= 1'b0;
      endcase
    end
  end

  always_comb begin
    line_o = 1'b1;
    if (busy_o) begin
      case (phase_q)
        PH_START: line_o = 1'b0;
        PH_DATA:  line_o = shreg_q[0];
        PH_PAR:   line_o = par_q;
        default:  line_o = 1'b1;
      endcase
    end
  end

  p_load_starts_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (busy_o && !line_o));

  p_idle_after_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(phase_q) == PH_STOP));

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        len_sel_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic [1:0]        stop_sel_i,
  input  logic [1:0]        rate_sel_i,
  input  logic              tx_en_i,
  input  logic              brk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o
);

  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              busy;
  logic              stop_end;
  logic              line;
  logic              seg_end;
  logic [TICK_W-1:0] seg_len;

  // next frame may start on the tick that closes the stop interval
  assign load       = hold_full && tx_en_i && (!busy || stop_end);
  assign tx_rdy_o   = !hold_full && tx_en_i;
  assign tx_empty_o = !busy;
  assign txd_o      = line && !brk_i;

  ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .take_i  (load),
    .full_o  (hold_full),
    .data_o  (hold_data)
  );

  ser_tx_timer #(.CW(TICK_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .tick_i    (tick_i),
    .restart_i (load),
    .len_i     (seg_len),
    .seg_end_o (seg_end)
  );

  ser_tx_frame #(.CW(TICK_W)) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .ld_data_i     (hold_data[7:0]),
    .ld_len_i      (len_sel_i),
    .ld_par_en_i   (par_en_i),
    .ld_par_even_i (par_even_i),
    .ld_rate_i     (rate_sel_i),
    .ld_stop_i     (stop_sel_i),
    .seg_end_i     (seg_end),
    .busy_o        (busy),
    .stop_end_o    (stop_end),
    .line_o        (line),
    .seg_len_o     (seg_len)
  );

  p_no_start_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !busy) |=> !busy);

  p_write_clears_rdy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rdy_o && wr_i) |=> !tx_rdy_o);

endmodule

// File: tb/ser_tx_top_tb_top.sv
module ser_tx_top_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] len_sel_i = 2'b11;
  logic       par_en_i = 1'b0;
  logic       par_even_i = 1'b0;
  logic [1:0] stop_sel_i = 2'b01;
  logic [1:0] rate_sel_i = 2'b10;
  logic       tx_en_i = 1'b1;
  logic       brk_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       txd_o, tx_rdy_o, tx_empty_o;

  int checks = 0;
  int failures = 0;
  bit mon_en = 1'b1;
  int rem = 0;

  bit    exp_bits[$];
  int    exp_len[$];
  string exp_tag[$];

  ser_tx_top dut_i (
    .clk_i, .rst_ni, .tick_i, .len_sel_i, .par_en_i, .par_even_i,
    .stop_sel_i, .rate_sel_i, .tx_en_i, .brk_i, .wr_i, .wdata_i,
    .txd_o, .tx_rdy_o, .tx_empty_o
  );

  always #10 clk_i = ~clk_i;

  initial forever begin
    @(negedge clk_i);
    tick_i = ~tick_i;
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // expected per-tick line levels for one frame, from the current mode inputs
  task automatic push_frame(input logic [7:0] d, input string tag);
    int bt, st, nb, tot;
    bit p;
    bt = (rate_sel_i == 2'b10) ? 16 : (rate_sel_i == 2'b11) ? 64 : 1;
    case (stop_sel_i)
      2'b10:   st = (bt == 1) ? 2 : bt + bt / 2;
      2'b11:   st = 2 * bt;
      default: st = bt;
    endcase
    nb = 5 + int'(len_sel_i);
    tot = 0;
    p = 1'b0;
    for (int i = 0; i < bt; i++) begin exp_bits.push_back(1'b0); tot++; end
    for (int b = 0; b < nb; b++) begin
      p ^= d[b];
      for (int i = 0; i < bt; i++) begin exp_bits.push_back(d[b]); tot++; end
    end
    if (par_en_i) begin
      for (int i = 0; i < bt; i++) begin
        exp_bits.push_back(par_even_i ? p : ~p);
        tot++;
      end
    end
    for (int i = 0; i < st; i++) begin exp_bits.push_back(1'b1); tot++; end
    exp_len.push_back(tot);
    exp_tag.push_back(tag);
  endtask

  task automatic send(input logic [7:0] d, input string tag);
    @(negedge clk_i);
    while (!tx_rdy_o) @(negedge clk_i);
    wr_i = 1'b1;
    wdata_i = d;
    push_frame(d, tag);
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk_i);
    while (exp_len.size() != 0 || rem != 0 || !tx_empty_o) @(negedge clk_i);
    repeat (6) @(negedge clk_i);
  endtask

  // monitor: compares the line on every counted tick with the scoreboard
  initial begin
    bit mism;
    int first_bad_act, first_bad_exp;
    string tag;
    mism = 0; first_bad_act = 0; first_bad_exp = 0; tag = "";
    forever begin
      @(negedge clk_i);
      #5;
      if (tick_i && mon_en && rst_ni) begin
        if (rem == 0 && txd_o == 1'b0) begin
          if (exp_len.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL R7 unexpected start bit actual=0 expected=1");
          end else begin
            rem = exp_len.pop_front();
            tag = exp_tag.pop_front();
            mism = 0;
          end
        end
        if (rem > 0) begin
          bit e;
          e = exp_bits.pop_front();
          if (txd_o !== e && !mism) begin
            mism = 1;
            first_bad_act = int'(txd_o);
            first_bad_exp = int'(e);
          end
          rem--;
          if (rem == 0) begin
            checks++;
            if (mism) begin
              failures++;
              $display("FAIL %s frame mismatch actual=%0d expected=%0d",
                       tag, first_bad_act, first_bad_exp);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL R-all watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    // R1 reset state
    check("R1 txd", int'(txd_o), 1);
    check("R1 tx_rdy", int'(tx_rdy_o), 1);
    check("R1 tx_empty", int'(tx_empty_o), 1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R2/R4 x16, 8 bits, 1 stop
    send(8'hA5, "R2_R4 x16 8b");
    check("R6 rdy low after write", int'(tx_rdy_o), 0);
    check("R8 empty before start", int'(tx_empty_o), 1);
    @(negedge clk_i);
    check("R6 rdy back after move", int'(tx_rdy_o), 1);
    check("R8 empty low in frame", int'(tx_empty_o), 0);
    drain();
    check("R8 empty after frame", int'(tx_empty_o), 1);
    check("R2 idle high", int'(txd_o), 1);

    // R2 shorter lengths at x1, upper bits masked
    rate_sel_i = 2'b01;
    for (int l = 0; l < 3; l++) begin
      len_sel_i = 2'(l);
      send(8'hE3, "R2 short length");
      drain();
    end
    len_sel_i = 2'b11;

    // R3 parity even and odd at x16
    rate_sel_i = 2'b10;
    par_en_i = 1'b1;
    par_even_i = 1'b1;
    send(8'h37, "R3 even parity"); drain();
    par_even_i = 1'b0;
    send(8'h37, "R3 odd parity"); drain();
    len_sel_i = 2'b01;
    send(8'h2C, "R3 odd parity 6b"); drain();
    len_sel_i = 2'b11;
    par_en_i = 1'b0;

    // R5 stop lengths, R4 x64
    stop_sel_i = 2'b10;
    send(8'h5A, "R5 1.5 stop x16"); drain();
    rate_sel_i = 2'b11;
    send(8'hC3, "R4_R5 1.5 stop x64"); drain();
    stop_sel_i = 2'b11;
    send(8'h81, "R4_R5 2 stop x64"); drain();
    rate_sel_i = 2'b10;
    send(8'h0F, "R5 2 stop x16"); drain();
    rate_sel_i = 2'b01;
    stop_sel_i = 2'b10;
    send(8'h96, "R5 1.5 stop x1"); drain();
    rate_sel_i = 2'b00;
    stop_sel_i = 2'b00;
    send(8'h3C, "R4_R5 code 00"); drain();

    // R6 back-to-back with no idle gap at x1
    rate_sel_i = 2'b01;
    stop_sel_i = 2'b01;
    send(8'h11, "R6 b2b first");
    send(8'hEE, "R6 b2b second");
    send(8'h70, "R6 b2b third");
    drain();

    // R7 write while buffer full is ignored
    rate_sel_i = 2'b10;
    send(8'h55, "R7 first");
    send(8'hAA, "R7 buffered");
    @(negedge clk_i);
    check("R7 rdy low while full", int'(tx_rdy_o), 0);
    wr_i = 1'b1; wdata_i = 8'hFF;
    @(negedge clk_i);
    wr_i = 1'b0;
    drain();
    repeat (200) @(negedge clk_i);
    check("R7 no extra frame", int'(tx_empty_o), 1);

    // R9 disable mid-frame, buffered write waits for enable
    send(8'h6B, "R9 running frame completes");
    repeat (40) @(negedge clk_i);
    tx_en_i = 1'b0;
    @(negedge clk_i);
    check("R9 rdy low when disabled", int'(tx_rdy_o), 0);
    drain();
    wr_i = 1'b1; wdata_i = 8'h9D;
    @(negedge clk_i);
    wr_i = 1'b0;
    repeat (300) @(negedge clk_i);
    check("R9 no start while disabled", int'(tx_empty_o), 1);
    check("R9 line idle while disabled", int'(txd_o), 1);
    push_frame(8'h9D, "R9 starts after enable");
    tx_en_i = 1'b1;
    drain();

    // R10 break forces low
    mon_en = 1'b0;
    brk_i = 1'b1;
    @(negedge clk_i);
    check("R10 break low", int'(txd_o), 0);
    repeat (50) @(negedge clk_i);
    check("R10 break held low", int'(txd_o), 0);
    brk_i = 1'b0;
    @(negedge clk_i);
    check("R10 release high", int'(txd_o), 1);
    repeat (4) @(negedge clk_i);
    mon_en = 1'b1;

    // R11 mode change mid-frame does not alter the frame
    rate_sel_i = 2'b10;
    send(8'hB4, "R11 format held");
    @(negedge clk_i);
    check("R11 frame running", int'(tx_empty_o), 0);
    rate_sel_i = 2'b01;
    par_en_i = 1'b1;
    len_sel_i = 2'b00;
    stop_sel_i = 2'b11;
    drain();

    check("R2 scoreboard empty", exp_len.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule